// File: doc/BRIEF.md
# Dirty-Band Refresh Scanner

This block keeps a record of which 4 KB pages of framebuffer memory have been written since the last refresh. When a refresh is requested, it turns that record into a short list of screen regions to redraw. It watches the memory write address bus and sets one dirty bit per page. One page of the indexed plane holds exactly four 1024-byte scanlines, so each page stands for a horizontal band four lines high. When a refresh starts, the scanner visits every band from the top of the frame down. It joins each run of consecutive dirty bands into one region and hands out one descriptor per run. A descriptor gives the first line and the number of lines, and always covers the full active width.

In true-colour mode there are two more planes, the direct-colour plane and the per-pixel control plane. Each of these uses four bytes per pixel, so one band spans four of their pages. A band then counts as dirty if its indexed page was written, or if any of its four direct or control pages was written. When the pass is over, the scanner clears the dirty bits in every plane from the lowest dirty band it found to the highest, so the next refresh only reports new writes. A palette change or an invalidate pulse marks the whole frame dirty. Descriptors leave through a valid/ready handshake, and the pass pauses while a descriptor is waiting. A one-cycle pulse marks the end of each pass.

Top module: `dirty_scan_top`

## Requirements
- R1: After reset every dirty bit is clear, `descValid` and `scanDone` are low, and a refresh issued then produces no descriptor.
- R2: A snooped write with plane code 0 (indexed plane) marks band `snoopAddr >> PAGE_SHIFT`; the low `PAGE_SHIFT` address bits have no effect on which band is marked.
- R3: A refresh emits one descriptor per maximal run of consecutive dirty bands, in ascending order, with `descYStart` = 4 × first band and `descLines` = 4 × run length.
- R4: A run that reaches the last band is closed and emitted at the end of the frame.
- R5: After a pass with at least one dirty band, the dirty bits of all planes between the lowest and highest dirty band are clear, so an immediate second refresh emits nothing.
- R6: With `trueColor` high, a write with plane code 1 (direct plane) or 2 (control plane) to page q marks band q/4, and dirty bands from different planes merge into one run.
- R7: With `trueColor` low, direct-plane and control-plane writes do not make a band dirty, but they stay recorded. Plane code 3 and pages beyond a plane's size are ignored in both modes.
- R8: A `markAll` pulse marks every band dirty, so the next refresh emits a single descriptor covering the whole frame.
- R9: A snooped write in the same cycle as the end-of-pass clear survives the clear.
- R10: While `descValid` is high and `descReady` is low, the descriptor is held unchanged and the pass stalls; each descriptor is transferred exactly once.
- R11: Every refresh ends with exactly one single-cycle `scanDone` pulse, including a pass that finds no dirty band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trueColor | input | 1 | Direct and control planes take part in the dirty test |
| snoopValid | input | 1 | A framebuffer write is being observed |
| snoopPlane | input | 2 | Plane of the write: 0 indexed, 1 direct, 2 control, 3 none |
| snoopAddr | input | $clog2(NUM_BANDS*4)+PAGE_SHIFT | Byte offset of the write within its plane |
| markAll | input | 1 | Palette change or invalidate: mark every page dirty |
| refreshStart | input | 1 | Start a scan pass (ignored while a pass runs) |
| descValid | output | 1 | Descriptor available |
| descReady | input | 1 | Consumer accepts the descriptor |
| descYStart | output | $clog2(NUM_BANDS*LINES+1) | First scanline of the region |
| descLines | output | $clog2(NUM_BANDS*LINES+1) | Number of scanlines in the region |
| scanDone | output | 1 | One-cycle pulse after a pass completes |

## Verification
The bench targets the following corner cases:

- **Runs at the frame edges.** Runs that touch band 0 or the last band, alternating patterns and a fully dirty frame are used. A scanner that drops the run still open at the end of the frame loses the bottom region. An off-by-one in the length arithmetic gives wrong line counts.
- **Clear ordering.** A write is held active across the whole pass. A design that applies the clear after the set silently forgets that page on the next refresh.
- **Consumer stalls.** Descriptors are drained under back-pressure. A scanner that keeps walking during a stall would change or lose descriptors.
- **True-colour planes.** Direct and control writes are checked in both colour modes, to catch a scanner that ignores the extra planes, or one that lets them leak into indexed mode.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // pages of the direct and control planes per band (four bytes per pixel)
  localparam int DIRECT_SCALE = 4;

  typedef enum logic [1:0] {
    PLANE_INDEX  = 2'd0,
    PLANE_DIRECT = 2'd1,
    PLANE_CTRL   = 2'd2,
    PLANE_NONE   = 2'd3
  } plane_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WAIT,
    ST_CLEAR
  } scan_state_e;

  // strobes from the scan control into the dirty-bit datapath
  typedef struct packed {
    logic clrEn;   // clear the band range this cycle
    logic lookEn;  // the band lookup is being consumed
  } ctl_strobe_t;

endpackage

// File: rtl/plane_map.sv
module plane_map #(
  parameter int PAGES  = 192,
  parameter int SCALE  = 1,
  parameter int PG_W   = 10,
  parameter int BAND_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setEn,
  input  logic [PG_W-1:0]   setPage,
  input  logic              markAll,
  input  logic              clrEn,
  input  logic [BAND_W-1:0] clrLo,
  input  logic [BAND_W-1:0] clrHi,
  input  logic [BAND_W-1:0] lookBand,
  output logic              lookDirty
);

  logic [PAGES-1:0] bits;
  logic [PAGES-1:0] nextBits;

  // set and markAll are applied after the clear, so a new write wins
  always_comb begin
    for (int i = 0; i < PAGES; i++) begin
      logic setHit;
      logic clrHit;
      setHit = setEn && (setPage == PG_W'(i));
      clrHit = clrEn && (clrLo <= BAND_W'(i / SCALE)) && (BAND_W'(i / SCALE) <= clrHi);
      nextBits[i] = markAll | setHit | (bits[i] & ~clrHit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bits <= '0;
    else       bits <= nextBits;
  end

  // OR of every page belonging to the looked-up band
  always_comb begin
    lookDirty = 1'b0;
    for (int k = 0; k < SCALE; k++) begin
      lookDirty = lookDirty | bits[int'(lookBand) * SCALE + k];
    end
  end

  a_r8_mark_all: assert property (@(posedge clk) disable iff (!rstN)
    markAll |=> (&bits));

  for (genvar i = 0; i < PAGES; i++) begin : g_chk
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (setEn && setPage == PG_W'(i)) |=> bits[i]);
    a_r5_range_cleared: assert property (@(posedge clk) disable iff (!rstN)
      (clrEn && !markAll && !(setEn && setPage == PG_W'(i)) &&
       clrLo <= BAND_W'(i / SCALE) && BAND_W'(i / SCALE) <= clrHi) |=> !bits[i]);
  end

endmodule

// File: rtl/dirty_map.sv
module dirty_map
  import scan_pkg::*;
#(
  parameter int BANDS  = 192,
  parameter int PG_W   = 10,
  parameter int BAND_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trueColor,
  input  logic              snoopValid,
  input  logic [1:0]        snoopPlane,
  input  logic [PG_W-1:0]   snoopPage,
  input  logic              markAll,
  input  ctl_strobe_t       strobe,
  input  logic [BAND_W-1:0] cursor,
  input  logic [BAND_W-1:0] clrLo,
  input  logic [BAND_W-1:0] clrHi,
  output logic              bandDirty
);

  localparam int NUM_PLANES = 3;

  logic [NUM_PLANES-1:0] planeHit;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    localparam int SC = (p == 0) ? 1 : DIRECT_SCALE;
    plane_map #(
      .PAGES (BANDS * SC),
      .SCALE (SC),
      .PG_W  (PG_W),
      .BAND_W(BAND_W)
    ) u_map (
      .clk      (clk),
      .rstN     (rstN),
      .setEn    (snoopValid && (snoopPlane == 2'(p))),
      .setPage  (snoopPage),
      .markAll  (markAll),
      .clrEn    (strobe.clrEn),
      .clrLo    (clrLo),
      .clrHi    (clrHi),
      .lookBand (cursor),
      .lookDirty(planeHit[p])
    );
  end

  always_comb begin
    bandDirty = strobe.lookEn &&
                (planeHit[PLANE_INDEX] ||
                 (trueColor && (planeHit[PLANE_DIRECT] || planeHit[PLANE_CTRL])));
  end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int BANDS  = 192,
  parameter int LINES  = 4,
  parameter int BAND_W = 8,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refreshStart,
  input  logic              bandDirty,
  input  logic              descReady,
  output logic [BAND_W-1:0] cursor,
  output logic [BAND_W-1:0] clrLo,
  output logic [BAND_W-1:0] clrHi,
  output ctl_strobe_t       strobe,
  output logic              descValid,
  output logic [LINE_W-1:0] yStart,
  output logic [LINE_W-1:0] lineCount,
  output logic              scanDone
);

  localparam int TOTAL = BANDS * LINES;

  scan_state_e       state;
  logic [BAND_W-1:0] runStart;
  logic              inRun;
  logic              anyDirty;
  logic              lastFlag;

  logic              isLast;
  logic              closeMid;
  logic              closeEnd;
  logic              emit;
  logic [LINE_W-1:0] nextY;
  logic [LINE_W-1:0] nextN;

  always_comb begin
    int firstI;
    int endI;
    isLast   = (cursor == BAND_W'(BANDS - 1));
    closeMid = inRun && !bandDirty;
    closeEnd = isLast && bandDirty;
    emit     = (state == ST_SCAN) && (closeMid || closeEnd);
    firstI   = inRun ? int'(runStart) : int'(cursor);
    endI     = closeEnd ? BANDS : int'(cursor);
    nextY    = LINE_W'(firstI * LINES);
    nextN    = LINE_W'((endI - firstI) * LINES);
  end

  always_comb begin
    strobe.lookEn = (state == ST_SCAN);
    strobe.clrEn  = (state == ST_CLEAR) && anyDirty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cursor    <= '0;
      runStart  <= '0;
      inRun     <= 1'b0;
      anyDirty  <= 1'b0;
      clrLo     <= '0;
      clrHi     <= '0;
      lastFlag  <= 1'b0;
      descValid <= 1'b0;
      yStart    <= '0;
      lineCount <= '0;
      scanDone  <= 1'b0;
    end else begin
      scanDone <= (state == ST_CLEAR);
      unique case (state)
        ST_IDLE: begin
          if (refreshStart) begin
            cursor   <= '0;
            inRun    <= 1'b0;
            anyDirty <= 1'b0;
            lastFlag <= 1'b0;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (bandDirty) begin
            if (!anyDirty) clrLo <= cursor;
            anyDirty <= 1'b1;
            clrHi    <= cursor;
          end
          if (emit) begin
            descValid <= 1'b1;
            yStart    <= nextY;
            lineCount <= nextN;
            inRun     <= 1'b0;
            lastFlag  <= isLast;
            state     <= ST_WAIT;
          end else begin
            if (bandDirty && !inRun) begin
              runStart <= cursor;
              inRun    <= 1'b1;
            end
            if (isLast) state <= ST_CLEAR;
          end
          if (!isLast) cursor <= cursor + 1'b1;
        end
        ST_WAIT: begin
          if (descReady) begin
            descValid <= 1'b0;
            state     <= lastFlag ? ST_CLEAR : ST_SCAN;
          end
        end
        ST_CLEAR: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(yStart) && $stable(lineCount)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  a_r3_desc_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> (lineCount != '0 && (int'(yStart) + int'(lineCount)) <= TOTAL));

  a_r5_clear_ordered: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |-> (clrLo <= clrHi));

endmodule

// File: rtl/dirty_scan_top.sv
module dirty_scan_top
  import scan_pkg::*;
#(
  parameter int NUM_BANDS  = 192,
  parameter int PAGE_SHIFT = 12,
  parameter int LINE_SHIFT = 10
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         trueColor,
  input  logic                                         snoopValid,
  input  logic [1:0]                                   snoopPlane,
  input  logic [$clog2(NUM_BANDS*4)+PAGE_SHIFT-1:0]    snoopAddr,
  input  logic                                         markAll,
  input  logic                                         refreshStart,
  output logic                                         descValid,
  input  logic                                         descReady,
  output logic [$clog2(NUM_BANDS*(1<<(PAGE_SHIFT-LINE_SHIFT))+1)-1:0] descYStart,
  output logic [$clog2(NUM_BANDS*(1<<(PAGE_SHIFT-LINE_SHIFT))+1)-1:0] descLines,
  output logic                                         scanDone
);

  localparam int LINES  = 1 << (PAGE_SHIFT - LINE_SHIFT);
  localparam int PG_W   = $clog2(NUM_BANDS * DIRECT_SCALE);
  localparam int AW     = PG_W + PAGE_SHIFT;
  localparam int BAND_W = $clog2(NUM_BANDS);
  localparam int LINE_W = $clog2(NUM_BANDS * LINES + 1);

  logic [PG_W-1:0]   snoopPage;
  logic              unusedOffset;
  logic              bandDirty;
  logic [BAND_W-1:0] cursor;
  logic [BAND_W-1:0] clrLo;
  logic [BAND_W-1:0] clrHi;
  ctl_strobe_t       strobe;

  assign snoopPage    = snoopAddr[AW-1:PAGE_SHIFT];
  assign unusedOffset = ^snoopAddr[PAGE_SHIFT-1:0];

  dirty_map #(
    .BANDS (NUM_BANDS),
    .PG_W  (PG_W),
    .BAND_W(BAND_W)
  ) u_map (
    .clk       (clk),
    .rstN      (rstN),
    .trueColor (trueColor),
    .snoopValid(snoopValid),
    .snoopPlane(snoopPlane),
    .snoopPage (snoopPage),
    .markAll   (markAll),
    .strobe    (strobe),
    .cursor    (cursor),
    .clrLo     (clrLo),
    .clrHi     (clrHi),
    .bandDirty (bandDirty)
  );

  scan_ctrl #(
    .BANDS (NUM_BANDS),
    .LINES (LINES),
    .BAND_W(BAND_W),
    .LINE_W(LINE_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .refreshStart(refreshStart),
    .bandDirty   (bandDirty),
    .descReady   (descReady),
    .cursor      (cursor),
    .clrLo       (clrLo),
    .clrHi       (clrHi),
    .strobe      (strobe),
    .descValid   (descValid),
    .yStart      (descYStart),
    .lineCount   (descLines),
    .scanDone    (scanDone)
  );

endmodule

// File: tb/sim_dirty_scan_top.sv
module sim_dirty_scan_top;

  localparam int NB  = 8;
  localparam int PS  = 12;
  localparam int LS  = 10;
  localparam int LPB = 4;
  localparam int AW  = $clog2(NB * 4) + PS;
  localparam int LW  = $clog2(NB * LPB + 1);

  // bit 8 = stall the consumer, bits 7:0 = indexed bands to dirty
  localparam logic [8:0] VEC [0:7] = '{
    9'h000, 9'h001, 9'h080, 9'h0C3, 9'h155, 9'h0FF, 9'h13C, 9'h192
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trueColor = 1'b0;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopPlane = 2'd0;
  logic [AW-1:0] snoopAddr = '0;
  logic          markAll = 1'b0;
  logic          refreshStart = 1'b0;
  logic          descValid;
  logic          descReady = 1'b1;
  logic [LW-1:0] descYStart;
  logic [LW-1:0] descLines;
  logic          scanDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dirty_scan_top #(.NUM_BANDS(NB), .PAGE_SHIFT(PS), .LINE_SHIFT(LS)) u0 (
    .clk(clk), .rstN(rstN), .trueColor(trueColor), .snoopValid(snoopValid),
    .snoopPlane(snoopPlane), .snoopAddr(snoopAddr), .markAll(markAll),
    .refreshStart(refreshStart), .descValid(descValid), .descReady(descReady),
    .descYStart(descYStart), .descLines(descLines), .scanDone(scanDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeAt(input logic [1:0] plane, input int page, input int off);
    @(negedge clk);
    snoopValid = 1'b1;
    snoopPlane = plane;
    snoopAddr  = AW'((page << PS) | off);
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  // runs a pass and compares the descriptors with the runs of 'mask'
  task automatic scanExpect(input logic [NB-1:0] mask, input bit stall, input string tag);
    int expY[NB];
    int expL[NB];
    int expN = 0;
    int gotY[NB];
    int gotL[NB];
    int gotN = 0;
    bit seenDone = 1'b0;
    bit prevStall = 1'b0;
    int lastY = 0;
    int lastL = 0;
    for (int b = 0; b < NB; b++) begin
      if (mask[b] && (b == 0 || !mask[b-1])) begin
        int e = b;
        for (int k = b; k < NB && mask[k]; k++) e = k + 1;
        expY[expN] = b * LPB;
        expL[expN] = (e - b) * LPB;
        expN++;
      end
    end
    @(negedge clk);
    refreshStart = 1'b1;
    @(negedge clk);
    refreshStart = 1'b0;
    for (int c = 0; c < 400 && !seenDone; c++) begin
      bit rdy;
      if (scanDone) seenDone = 1'b1;
      rdy = stall ? (c % 3 == 2) : 1'b1;
      if (descValid) begin
        if (prevStall) begin
          check(int'(descYStart) == lastY, "R10 held yStart", int'(descYStart), lastY);
          check(int'(descLines) == lastL, "R10 held lines", int'(descLines), lastL);
        end
        if (rdy) begin
          if (gotN < NB) begin
            gotY[gotN] = int'(descYStart);
            gotL[gotN] = int'(descLines);
          end
          gotN++;
        end
        prevStall = !rdy;
        lastY = int'(descYStart);
        lastL = int'(descLines);
      end else begin
        prevStall = 1'b0;
      end
      descReady = rdy;
      if (!seenDone) @(negedge clk);
    end
    descReady = 1'b1;
    check(seenDone, {tag, " R11 done seen"}, int'(seenDone), 1);
    @(negedge clk);
    check(!scanDone, "R11 done single pulse", int'(scanDone), 0);
    check(gotN == expN, {tag, " descriptor count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotY[i] == expY[i], {tag, " yStart"}, gotY[i], expY[i]);
      check(gotL[i] == expL[i], {tag, " lines"}, gotL[i], expL[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!descValid, "R1 descValid in reset", int'(descValid), 0);
    check(!scanDone, "R1 scanDone in reset", int'(scanDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!descValid && !scanDone, "R1 idle after reset", int'(descValid), 0);
    scanExpect(8'h00, 1'b0, "R1 empty");

    // R2: page taken from the upper address bits only
    writeAt(2'd0, 3, 12'hFFF);
    scanExpect(8'h08, 1'b0, "R2");

    // R3 / R4 / R10: table of band patterns, each followed by the R5 re-scan
    for (int v = 0; v < 8; v++) begin
      logic [NB-1:0] m;
      m = VEC[v][NB-1:0];
      for (int b = 0; b < NB; b++) if (m[b]) writeAt(2'd0, b, b * 53 + 1);
      if (VEC[v][8])   scanExpect(m, 1'b1, "R10 R3");
      else if (m[NB-1]) scanExpect(m, 1'b0, "R3 R4");
      else             scanExpect(m, 1'b0, "R3");
      scanExpect(8'h00, 1'b0, "R5 cleared");
    end

    // R7: extra planes ignored in indexed mode, kept for true colour
    trueColor = 1'b0;
    writeAt(2'd1, 4, 0);        // direct page 4 -> band 1
    writeAt(2'd3, 2, 0);        // no plane
    writeAt(2'd0, 9, 0);        // beyond indexed plane
    scanExpect(8'h00, 1'b0, "R7 indexed mode");
    trueColor = 1'b1;
    scanExpect(8'h02, 1'b0, "R7 retained");

    // R6: direct and control planes merge with each other
    writeAt(2'd1, 13, 0);       // band 3
    writeAt(2'd2, 16, 0);       // band 4
    writeAt(2'd2, 31, 0);       // band 7
    scanExpect(8'h98, 1'b0, "R6");
    scanExpect(8'h00, 1'b0, "R6 R5 cleared");
    trueColor = 1'b0;

    // R8: mark everything
    @(negedge clk);
    markAll = 1'b1;
    @(negedge clk);
    markAll = 1'b0;
    scanExpect(8'hFF, 1'b0, "R8");
    scanExpect(8'h00, 1'b0, "R8 R5 cleared");

    // R9: a write held across the clear cycle survives it
    writeAt(2'd0, 2, 0);
    @(negedge clk);
    snoopValid = 1'b1;
    snoopPlane = 2'd0;
    snoopAddr  = AW'(5 << PS);
    scanExpect(8'h24, 1'b0, "R9 first");
    snoopValid = 1'b0;
    scanExpect(8'h20, 1'b0, "R9 survived");
    scanExpect(8'h00, 1'b0, "R9 R5 cleared");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule